// File: doc/BRIEF.md
# Galloping Pattern Memory Self-Test Sequencer

This block runs a galloping-pattern characterization test on a small single-bit RAM. When started, it fills the whole array with a background value. It then takes each cell in turn as the base cell and inverts it. With the base cell inverted, it reads the base cell and one other cell, alternating between them, until every other cell has been read. Last, it puts the base cell back to the background value. The whole procedure runs once with a background of 0 and then again with a background of 1. The test length grows with the square of the depth, so the block is meant for small arrays and for characterization work, not for production screening.

The sequencer issues one memory operation per clock. The RAM is expected to have a synchronous read: data for a read issued in one cycle is presented in the next cycle. A comparison stage checks every read against the expected value. The base cell must read the inverted background, and any other cell must read the background. The first mismatch raises a sticky fail flag and captures the base and other addresses that were active at that read. The test always runs to its full, fixed length and then raises done.

Top module: `galpat_seq`

## Requirements
- R1: After reset, `done_o`, `fail_o`, `mem_we_o` and `mem_re_o` are all 0.
- R2: A `start_i` pulse in the idle or done state starts a run and clears `done_o` and `fail_o`. A `start_i` pulse during a run is ignored, and the operation sequence continues unchanged.
- R3: Each background pass begins with N = 2^AW write cycles. These write the background value to addresses 0 through N-1 in ascending order, one per clock.
- R4: For each base address b, taken in ascending order, the block first writes the inverted background to b in a single write cycle. After the reads for that base cell it writes the background back to b in a single write cycle. The inverted value is written directly; the cell is not read first to form it.
- R5: Between those two writes, the block issues read pairs. Each pair is a read of b followed by a read of an other address o. The other addresses run in ascending order over 0 to N-1 and skip o = b, which gives 2(N-1) read cycles.
- R6: Read data on `mem_rdata_i` is taken in the cycle after the read was issued. It is compared with the inverted background for a base-cell read and with the background for an other-cell read. A mismatch raises `fail_o` from the following cycle onward.
- R7: The pass with background 0 is followed by the same procedure with background 1, for 2N + 4N^2 operations in total. `done_o` rises in the cycle after the last operation and stays high until the next accepted start.
- R8: The first mismatch of a run latches the base address into `fail_base_o` and the other address of that read pair into `fail_other_o`. Later mismatches in the same run change neither `fail_o` nor the latched pair.
- R9: `mem_we_o` and `mem_re_o` are never high in the same cycle. Neither is high while the block is idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle or done |
| mem_addr_o | output | AW | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_wdata_o | output | 1 | Memory write data |
| mem_rdata_i | input | 1 | Memory read data, valid one cycle after a read |
| done_o | output | 1 | Run complete, held until the next start |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_base_o | output | AW | Base address at the first mismatch |
| fail_other_o | output | AW | Other address at the first mismatch |

## Verification
Two things often happen in the same cycle. The comparison stage judges the data of the previous read while the sequencer is already issuing the next operation, and that operation is often the write that restores the base cell or inverts the next one. The bench provokes this overlap with stuck-at cells at the first and last address and with coupling faults in which a write to one cell inverts another. Each fault is injected into a bench RAM model and also into an independent walk over the expected operation list, and the run is judged on two things: the exact cycle in which `fail_o` rises, and the address pair that is captured. A start pulse issued in the middle of a run checks that a second launch cannot overlap an active sequence.

// File: rtl/galpat_pkg.sv
package galpat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_INV,
    ST_RD_BASE,
    ST_RD_OTHER,
    ST_RESTORE,
    ST_DONE
  } galpat_st_e;
endpackage

// File: rtl/galpat_ctrl.sv
module galpat_ctrl
  import galpat_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          launch_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic          re_o,
  output logic          wdata_o,
  output logic          exp_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] other_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  galpat_st_e    st_q, st_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] oth_q, oth_d;
  logic          bg_q, bg_d;
  logic [AW:0]   oth_inc1, oth_nxt;
  logic [AW-1:0] oth_first;

  assign launch_o  = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
  assign oth_first = (base_q == '0) ? AW'(1) : '0;
  assign oth_inc1  = {1'b0, oth_q} + 1'b1;
  // skip the base index; a carry into bit AW marks the end of the sweep
  assign oth_nxt   = (!oth_inc1[AW] && oth_inc1[AW-1:0] == base_q) ? oth_inc1 + 1'b1 : oth_inc1;

  always_comb begin
    st_d   = st_q;
    base_d = base_q;
    oth_d  = oth_q;
    bg_d   = bg_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (launch_o) begin
        st_d   = ST_FILL;
        base_d = '0;
        bg_d   = 1'b0;
      end
      ST_FILL: begin
        if (base_q == LAST) begin
          base_d = '0;
          st_d   = ST_INV;
        end else begin
          base_d = base_q + 1'b1;
        end
      end
      ST_INV: begin
        oth_d = oth_first;
        st_d  = ST_RD_BASE;
      end
      ST_RD_BASE: st_d = ST_RD_OTHER;
      ST_RD_OTHER: begin
        if (oth_nxt[AW]) begin
          st_d = ST_RESTORE;
        end else begin
          oth_d = oth_nxt[AW-1:0];
          st_d  = ST_RD_BASE;
        end
      end
      ST_RESTORE: begin
        if (base_q != LAST) begin
          base_d = base_q + 1'b1;
          st_d   = ST_INV;
        end else if (!bg_q) begin
          bg_d   = 1'b1;
          base_d = '0;
          st_d   = ST_FILL;
        end else begin
          st_d = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
      oth_q  <= '0;
      bg_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      base_q <= base_d;
      oth_q  <= oth_d;
      bg_q   <= bg_d;
    end
  end

  always_comb begin
    addr_o  = base_q;
    we_o    = 1'b0;
    re_o    = 1'b0;
    wdata_o = bg_q;
    exp_o   = bg_q;
    unique case (st_q)
      ST_FILL, ST_RESTORE: we_o = 1'b1;
      ST_INV: begin
        we_o    = 1'b1;
        wdata_o = ~bg_q;
      end
      ST_RD_BASE: begin
        re_o  = 1'b1;
        exp_o = ~bg_q;
      end
      ST_RD_OTHER: begin
        re_o   = 1'b1;
        addr_o = oth_q;
      end
      default: ;
    endcase
  end

  assign base_o  = base_q;
  assign other_o = oth_q;
  assign done_o  = (st_q == ST_DONE);

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && re_o)); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE || st_q == ST_DONE) |-> !we_o && !re_o); // R9
  AST_OTHER_SKIPS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD_OTHER) |-> (oth_q != base_q)); // R5
  AST_BASE_THEN_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD_BASE) |=> (st_q == ST_RD_OTHER) && $stable(base_q)); // R5
  AST_INV_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INV) |=> (st_q == ST_RD_BASE)); // R4
endmodule

// File: rtl/galpat_chk.sv
module galpat_chk #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic          exp_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] other_i,
  input  logic          rdata_i,
  output logic          fail_o,
  output logic [AW-1:0] fail_base_o,
  output logic [AW-1:0] fail_other_o
);
  logic          rd_q, exp_q, miss;
  logic [AW-1:0] base_q, oth_q;

  // align issue-cycle context with the returning read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      exp_q  <= 1'b0;
      base_q <= '0;
      oth_q  <= '0;
    end else begin
      rd_q   <= rd_i;
      exp_q  <= exp_i;
      base_q <= base_i;
      oth_q  <= other_i;
    end
  end

  assign miss = rd_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o       <= 1'b0;
      fail_base_o  <= '0;
      fail_other_o <= '0;
    end else if (clr_i) begin
      fail_o       <= 1'b0;
    end else if (miss && !fail_o) begin
      fail_o       <= 1'b1;
      fail_base_o  <= base_q;
      fail_other_o <= oth_q;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clr_i |=> fail_o); // R8
  AST_PAIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> $stable(fail_base_o) && $stable(fail_other_o)); // R8
  AST_MISS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss && !clr_i |=> fail_o); // R6
endmodule

// File: rtl/galpat_seq.sv
module galpat_seq #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic          mem_wdata_o,
  input  logic          mem_rdata_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_base_o,
  output logic [AW-1:0] fail_other_o
);
  logic          launch, exp;
  logic [AW-1:0] base, other;

  galpat_ctrl #(.AW(AW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .launch_o (launch),
    .addr_o   (mem_addr_o),
    .we_o     (mem_we_o),
    .re_o     (mem_re_o),
    .wdata_o  (mem_wdata_o),
    .exp_o    (exp),
    .base_o   (base),
    .other_o  (other),
    .done_o   (done_o)
  );

  galpat_chk #(.AW(AW)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (launch),
    .rd_i         (mem_re_o),
    .exp_i        (exp),
    .base_i       (base),
    .other_i      (other),
    .rdata_i      (mem_rdata_i),
    .fail_o       (fail_o),
    .fail_base_o  (fail_base_o),
    .fail_other_o (fail_other_o)
  );

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o); // R7
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !done_o && !fail_o); // R2
endmodule

// File: tb/galpat_seq_tb_top.sv
module galpat_seq_tb_top;
  localparam int AW   = 4;
  localparam int N    = 1 << AW;
  localparam int NOPS = 2 * N + 4 * N * N;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re, mem_wdata;
  logic          mem_rdata = 1'b0;
  logic          done_o, fail_o;
  logic [AW-1:0] fail_base_o, fail_other_o;

  always #2.5 clk_i = ~clk_i;

  galpat_seq #(.AW(AW)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mem_addr_o   (mem_addr),
    .mem_we_o     (mem_we),
    .mem_re_o     (mem_re),
    .mem_wdata_o  (mem_wdata),
    .mem_rdata_i  (mem_rdata),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .fail_base_o  (fail_base_o),
    .fail_other_o (fail_other_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // fault model: 0 none, 1 cell f_a stuck at f_v, 2 write change on f_a inverts f_b
  int   f_kind = 0, f_a = 0, f_b = 0;
  logic f_v = 1'b0;

  logic ram [N];
  logic init_ram [N];
  logic load_req = 1'b0;

  int    op_addr [NOPS];
  bit    op_we [NOPS], op_re [NOPS], op_wd [NOPS], op_exp [NOPS];
  int    op_base [NOPS], op_oth [NOPS];
  string op_tag [NOPS];

  function automatic logic mem_rd(input logic m [N], input int a);
    return (f_kind == 1 && a == f_a) ? f_v : m[a];
  endfunction

  task automatic mem_wr(ref logic m [N], input int a, input logic d);
    if (f_kind == 2 && a == f_a && m[a] !== d) m[f_b] = ~m[f_b];
    m[a] = d;
  endtask

  always @(posedge clk_i) begin
    if (load_req) begin
      for (int i = 0; i < N; i++) ram[i] = init_ram[i];
    end else begin
      if (mem_we) mem_wr(ram, int'(mem_addr), mem_wdata);
      if (mem_re) mem_rdata <= mem_rd(ram, int'(mem_addr));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic add_op(inout int k, input int a, input bit we, input bit d, input bit ex,
                        input int b, input int o, input string tag);
    op_addr[k] = a; op_we[k] = we; op_re[k] = !we; op_wd[k] = we ? d : 1'b0;
    op_exp[k] = ex; op_base[k] = b; op_oth[k] = o; op_tag[k] = tag;
    k++;
  endtask

  // expected operation list built from R3, R4, R5, R7
  task automatic build_ops();
    int k = 0;
    for (int bg = 0; bg < 2; bg++) begin
      for (int a = 0; a < N; a++) add_op(k, a, 1, bit'(bg), 0, 0, 0, "R3");
      for (int b = 0; b < N; b++) begin
        add_op(k, b, 1, !bit'(bg), 0, b, 0, "R4");
        for (int o = 0; o < N; o++) begin
          if (o == b) continue;
          add_op(k, b, 0, 0, !bit'(bg), b, o, "R5");
          add_op(k, o, 0, 0, bit'(bg), b, o, "R5");
        end
        add_op(k, b, 1, bit'(bg), 0, b, 0, "R4");
      end
    end
  endtask

  // walks the op list over a faulty memory; returns first failing op index or -1
  task automatic ref_walk(output int idx, output int fb, output int fo);
    logic m [N];
    for (int i = 0; i < N; i++) m[i] = init_ram[i];
    idx = -1; fb = 0; fo = 0;
    for (int k = 0; k < NOPS; k++) begin
      if (op_we[k]) mem_wr(m, op_addr[k], op_wd[k]);
      else if (idx < 0 && mem_rd(m, op_addr[k]) !== op_exp[k]) begin
        idx = k; fb = op_base[k]; fo = op_oth[k];
      end
    end
  endtask

  task automatic run_case(input int kind, input int a, input int b, input logic v,
                          input int want_fb, input int want_fo);
    int fidx, efb, efo, flag_at;
    logic [AW-1:0] hb, ho;
    f_kind = kind; f_a = a; f_b = b; f_v = v;
    for (int i = 0; i < N; i++) init_ram[i] = logic'($urandom_range(0, 1));
    ref_walk(fidx, efb, efo);
    if (want_fb >= 0) begin
      chk(efb == want_fb && efo == want_fo, "R6 ref pair", efb * 100 + efo, want_fb * 100 + want_fo);
    end
    flag_at = (fidx < 0) ? NOPS + 10 : fidx + 2;
    @(negedge clk_i); load_req = 1'b1;
    @(negedge clk_i); load_req = 1'b0; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(!done_o && !fail_o, "R2 start clears", {30'd0, done_o, fail_o}, 0);
    for (int k = 0; k < NOPS; k++) begin
      chk(int'(mem_addr) == op_addr[k] && mem_we == op_we[k] && mem_re == op_re[k]
          && (!op_we[k] || mem_wdata == op_wd[k]), op_tag[k],
          int'(mem_addr) * 8 + mem_we * 4 + mem_re * 2 + mem_wdata,
          op_addr[k] * 8 + op_we[k] * 4 + op_re[k] * 2 + op_wd[k]);
      chk(!(mem_we && mem_re), "R9", mem_we + mem_re, 1);
      chk(fail_o == (k >= flag_at), "R6 flag timing", fail_o, int'(k >= flag_at));
      chk(!done_o, "R7 done early", done_o, 0);
      start_i = (k == 300);  // R2: ignored mid-run
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(done_o, "R7 done", done_o, 1);
    chk(!mem_we && !mem_re, "R9 done quiet", mem_we + mem_re, 0);
    chk(fail_o == (fidx >= 0), "R8 fail", fail_o, int'(fidx >= 0));
    if (fidx >= 0)
      chk(int'(fail_base_o) == efb && int'(fail_other_o) == efo, "R8 pair",
          int'(fail_base_o) * 100 + int'(fail_other_o), efb * 100 + efo);
    hb = fail_base_o; ho = fail_other_o;
    repeat (5) @(negedge clk_i);
    chk(done_o && fail_o == (fidx >= 0) && hb == fail_base_o && ho == fail_other_o,
        "R7 R8 hold", {29'd0, done_o, fail_o, 1'b0}, {29'd0, 1'b1, fidx >= 0, 1'b0});
  endtask

  initial begin
    int s, a, b;
    s = $urandom(32'h6a1f);
    build_ops();
    repeat (3) @(negedge clk_i);
    chk(!done_o && !fail_o && !mem_we && !mem_re, "R1 reset",
        {28'd0, done_o, fail_o, mem_we, mem_re}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !fail_o && !mem_we && !mem_re, "R1 idle",
        {28'd0, done_o, fail_o, mem_we, mem_re}, 0);
    run_case(0, 0, 0, 1'b0, -1, 0);
    run_case(1, 0, 0, 1'b0, 0, 1);          // R6 cell 0 stuck at 0
    run_case(1, N - 1, 0, 1'b1, 0, N - 1);  // R6 last cell stuck at 1
    run_case(0, 0, 0, 1'b0, -1, 0);         // R2 restart after failure
    for (int i = 0; i < 3; i++) begin
      run_case(1, $urandom_range(0, N - 1), 0, logic'($urandom_range(0, 1)), -1, 0);
    end
    for (int i = 0; i < 3; i++) begin
      a = $urandom_range(0, N - 1);
      b = (a + 1 + $urandom_range(0, N - 2)) % N;
      run_case(2, a, b, 1'b0, -1, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule